// File: doc/BRIEF.md
# Cooperative Round-Robin Task Queue Scheduler

This block arbitrates between a set of hardware task queues. With the default parameters there are 57 of them. Queue 0 takes graphics work only. Queues 1 to 56 take compute work, which corresponds to seven compute pipes of eight queues each. Each queue is a small FIFO of task descriptors. A single execution slot is handed to the head task of one queue at a time, and the queues are visited in rotating order. The running task can report that it finished or that it paused. A paused task keeps its place at the head of its queue, and the scheduler moves on to the next queue, so a stalled queue never holds up the rest.

Submissions enter through a single port that carries a graphics/compute flag, a queue index and a descriptor. A graphics submission always lands in queue 0, whatever queue index it carries. A compute submission must name an index from 1 to `NQ-1`; any other index is flagged as invalid and the descriptor is not stored. A global count of outstanding tasks rises on every accepted submission and falls on every retirement. The block is idle exactly when that count is zero.

The control is a two-state machine:
- `SEEK`: the scheduler looks for the first non-empty queue at or after the rotation pointer, using a 64-bit occupancy map. If it finds one, it loads the pointer with that queue (transition *grant*) and enters `RUN`. If every queue is empty, it stays in `SEEK` (transition *wait*).
- `RUN`: the head task of the pointed queue is presented on the run port. The task can finish (transition *retire*), which removes the descriptor, lowers the count, moves the pointer one past the granted queue and returns to `SEEK`. The task can pause (transition *yield*), which moves the pointer on without removing anything and also returns to `SEEK`. If the task does neither, the scheduler stays in `RUN` (transition *hold*).

Top module: `rrs_sched`

## Requirements
- R1: After reset, `idle` is 1, `pending` is 0, `run_valid` is 0 and the rotation pointer is 0, so queue 0 is the first queue examined.
- R2: A submission with `sub_gfx`=1 is always legal and goes to queue 0, whatever `sub_qid` holds.
- R3: A submission with `sub_gfx`=0 and `sub_qid` equal to 0 or to `NQ` or above raises `sub_bad` and holds `sub_ready` at 0. Nothing is stored and `pending` does not change.
- R4: Each queue holds `DEPTH` descriptors. `sub_ready` is 1 for a legal target that is not full and 0 for one that is full. A submission is accepted on a clock edge where `sub_valid` and `sub_ready` are both 1.
- R5: In `SEEK`, the scheduler grants the first non-empty queue met when counting upward from the pointer modulo `NQ`. `run_valid` rises in the cycle after the edge on which the scheduler sees that queue occupied, and a descriptor becomes visible one edge after it is accepted.
- R6: While `RUN` holds, `run_valid` stays 1 and `run_qid` and `run_task` stay unchanged. `run_task` is the head descriptor of queue `run_qid`.
- R7: `run_done` in `RUN` removes the head descriptor, lowers `pending` by one and sets the pointer to `run_qid+1` modulo `NQ`, followed by a return to `SEEK`.
- R8: `run_yield` without `run_done` in `RUN` leaves the descriptor at the head of its queue, sets the pointer to `run_qid+1` modulo `NQ` and returns to `SEEK`. `run_valid` is 0 in the next cycle.
- R9: When `run_done` and `run_yield` are both 1, the task is retired as in R7.
- R10: `pending` rises by one on an accepted submission and falls by one on a retirement. When both happen in the same cycle it does not change.
- R11: `idle` is 1 exactly when `pending` is 0. No task is granted while `idle` is 1.
- R12: Empty queues are never granted. With all queues empty, `run_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | Submission request |
| sub_gfx | input | 1 | 1 = graphics submission (queue 0), 0 = compute |
| sub_qid | input | QW | Compute queue index |
| sub_task | input | DW | Task descriptor to enqueue |
| sub_ready | output | 1 | Target queue is legal and has room |
| sub_bad | output | 1 | Submission names an illegal compute queue |
| run_valid | output | 1 | A task holds the execution slot |
| run_qid | output | QW | Queue of the running task |
| run_task | output | DW | Descriptor of the running task |
| run_yield | input | 1 | Running task pauses |
| run_done | input | 1 | Running task finished |
| idle | output | 1 | No outstanding task |
| pending | output | CW | Outstanding task count |

## Verification
The bench builds the block with its defaults: 57 queues, a depth of 4 and 16-bit descriptors. The queue index is 6 bits wide, so the illegal compute indices 0 and 57 to 63 can be driven directly, and the rotation wraps from queue 56 back to queue 0. A depth of 4 lets directed stimulus fill a queue and observe back-pressure within a few cycles. A long randomized phase mixes submissions, yields and retirements so that every queue fills, wraps and drains while a behavioural model follows each cycle.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [0:0] {
        SEEK = 1'b0,
        RUN  = 1'b1
    } rrs_state_e;

    localparam int unsigned MAP_W = 64;
endpackage

// File: rtl/rrs_task_fifo.sv
module rrs_task_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [DW-1:0]   mem [DEPTH];
    logic [AW-1:0]   rd_ix;
    logic [AW-1:0]   wr_ix;
    logic [CNTW-1:0] fill;
    logic            do_push;
    logic            do_pop;

    assign full    = (fill == CNTW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ix];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ix] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ix <= '0;
            wr_ix <= '0;
            fill  <= '0;
        end else begin
            if (do_push) begin
                wr_ix <= (wr_ix == AW'(DEPTH - 1)) ? '0 : wr_ix + 1'b1;
            end
            if (do_pop) begin
                rd_ix <= (rd_ix == AW'(DEPTH - 1)) ? '0 : rd_ix + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/rrs_rr_pick.sv
module rrs_rr_pick #(
    parameter int NQ    = 57,
    parameter int QW    = 6,
    parameter int MAP_W = 64
) (
    input  logic [MAP_W-1:0] occ_map,
    input  logic [QW-1:0]    from_q,
    output logic             hit,
    output logic [QW-1:0]    sel_q
);
    always_comb begin
        hit   = 1'b0;
        sel_q = from_q;
        for (int i = NQ - 1; i >= 0; i--) begin
            int idx;
            idx = int'(from_q) + i;
            if (idx >= NQ) begin
                idx = idx - NQ;
            end
            if (occ_map[idx]) begin
                hit   = 1'b1;
                sel_q = QW'(idx);
            end
        end
    end
endmodule

// File: rtl/rrs_pend_ctr.sv
module rrs_pend_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up,
    input  logic          down,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({up, down})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rrs_sched.sv
module rrs_sched #(
    parameter int NQ    = 57,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    parameter int QW    = $clog2(NQ),
    parameter int CW    = $clog2(NQ * DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sub_valid,
    input  logic          sub_gfx,
    input  logic [QW-1:0] sub_qid,
    input  logic [DW-1:0] sub_task,
    output logic          sub_ready,
    output logic          sub_bad,
    output logic          run_valid,
    output logic [QW-1:0] run_qid,
    output logic [DW-1:0] run_task,
    input  logic          run_yield,
    input  logic          run_done,
    output logic          idle,
    output logic [CW-1:0] pending
);
    import rrs_pkg::*;

    localparam int MW = int'(MAP_W);

    rrs_state_e    st_q, st_d;
    logic [QW-1:0] ptr_q, ptr_d;

    logic [DW-1:0] head_v [NQ];
    logic [NQ-1:0] full_v;
    logic [NQ-1:0] empty_v;
    logic [MW-1:0] occ_map;

    logic [QW-1:0] tgt_q;
    logic          legal;
    logic          tgt_full;
    logic          accept;
    logic          retire;
    logic          pick_hit;
    logic [QW-1:0] pick_q;
    logic [QW-1:0] ptr_after;

    // Submission decode
    assign tgt_q  = sub_gfx ? '0 : sub_qid;
    assign legal  = sub_gfx || ((sub_qid != '0) && (int'(sub_qid) < NQ));

    always_comb begin
        tgt_full = 1'b1;
        for (int q = 0; q < NQ; q++) begin
            if (tgt_q == QW'(q)) begin
                tgt_full = full_v[q];
            end
        end
    end

    assign sub_ready = legal && !tgt_full;
    assign sub_bad   = sub_valid && !legal;
    assign accept    = sub_valid && sub_ready;
    assign retire    = (st_q == RUN) && run_done;

    // Per-queue storage
    for (genvar q = 0; q < NQ; q++) begin : g_q
        rrs_task_fifo #(
            .DW    (DW),
            .DEPTH (DEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (accept && (tgt_q == QW'(q))),
            .din   (sub_task),
            .pop   (retire && (ptr_q == QW'(q))),
            .head  (head_v[q]),
            .full  (full_v[q]),
            .empty (empty_v[q])
        );
    end

    // Occupancy map, padded to the fixed map width
    for (genvar b = 0; b < MW; b++) begin : g_map
        if (b < NQ) begin : g_live
            assign occ_map[b] = !empty_v[b];
        end else begin : g_pad
            assign occ_map[b] = 1'b0;
        end
    end

    rrs_rr_pick #(
        .NQ    (NQ),
        .QW    (QW),
        .MAP_W (MW)
    ) u_pick (
        .occ_map (occ_map),
        .from_q  (ptr_q),
        .hit     (pick_hit),
        .sel_q   (pick_q)
    );

    assign ptr_after = (int'(ptr_q) == NQ - 1) ? '0 : ptr_q + 1'b1;

    // Next state and pointer
    always_comb begin
        st_d  = st_q;
        ptr_d = ptr_q;
        unique case (st_q)
            SEEK: begin
                if (pick_hit) begin
                    st_d  = RUN;
                    ptr_d = pick_q;
                end
            end
            RUN: begin
                if (run_done || run_yield) begin
                    st_d  = SEEK;
                    ptr_d = ptr_after;
                end
            end
            default: begin
                st_d = SEEK;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SEEK;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    // Outputs
    always_comb begin
        run_valid = 1'b0;
        run_qid   = ptr_q;
        run_task  = '0;
        unique case (st_q)
            SEEK: begin
                run_valid = 1'b0;
            end
            RUN: begin
                run_valid = 1'b1;
                for (int q = 0; q < NQ; q++) begin
                    if (ptr_q == QW'(q)) begin
                        run_task = head_v[q];
                    end
                end
            end
            default: begin
                run_valid = 1'b0;
            end
        endcase
    end

    rrs_pend_ctr #(
        .CW (CW)
    ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .up    (accept),
        .down  (retire),
        .count (pending)
    );

    assign idle = (pending == '0);
endmodule

// File: rtl/rrs_sched_chk.sv
module rrs_sched_chk #(
    parameter int QW = 6,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sub_valid,
    input logic          sub_gfx,
    input logic          sub_ready,
    input logic          sub_bad,
    input logic          run_valid,
    input logic [QW-1:0] run_qid,
    input logic [DW-1:0] run_task,
    input logic          run_yield,
    input logic          run_done,
    input logic          idle,
    input logic [CW-1:0] pending
);
    // R10
    cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && sub_ready && !(run_valid && run_done)) |=> (pending == $past(pending) + 1'b1));

    // R7
    cnt_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && run_done && !(sub_valid && sub_ready)) |=> (pending == $past(pending) - 1'b1));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && run_done && sub_valid && sub_ready) |=> $stable(pending));

    // R6
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && !run_done && !run_yield) |=> (run_valid && $stable(run_qid) && $stable(run_task)));

    // R8
    yield_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && run_yield) |=> !run_valid);

    // R3
    bad_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_bad |-> !sub_ready);

    // R2
    gfx_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && sub_gfx) |-> !sub_bad);

    // R11
    idle_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !run_valid);
endmodule

bind rrs_sched rrs_sched_chk #(
    .QW (QW),
    .DW (DW),
    .CW (CW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sub_valid (sub_valid),
    .sub_gfx   (sub_gfx),
    .sub_ready (sub_ready),
    .sub_bad   (sub_bad),
    .run_valid (run_valid),
    .run_qid   (run_qid),
    .run_task  (run_task),
    .run_yield (run_yield),
    .run_done  (run_done),
    .idle      (idle),
    .pending   (pending)
);

// File: tb/tb_rrs_sched.sv
`timescale 1ns/1ps
module tb_rrs_sched;
    localparam int NQ    = 57;
    localparam int DEPTH = 4;
    localparam int DW    = 16;
    localparam int QW    = $clog2(NQ);
    localparam int CW    = $clog2(NQ * DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sub_valid = 1'b0;
    logic          sub_gfx = 1'b0;
    logic [QW-1:0] sub_qid = '0;
    logic [DW-1:0] sub_task = '0;
    logic          sub_ready;
    logic          sub_bad;
    logic          run_valid;
    logic [QW-1:0] run_qid;
    logic [DW-1:0] run_task;
    logic          run_yield = 1'b0;
    logic          run_done = 1'b0;
    logic          idle;
    logic [CW-1:0] pending;

    always #4 clk = ~clk;

    rrs_sched #(.NQ(NQ), .DEPTH(DEPTH), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .sub_valid(sub_valid), .sub_gfx(sub_gfx), .sub_qid(sub_qid), .sub_task(sub_task),
        .sub_ready(sub_ready), .sub_bad(sub_bad),
        .run_valid(run_valid), .run_qid(run_qid), .run_task(run_task),
        .run_yield(run_yield), .run_done(run_done),
        .idle(idle), .pending(pending)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int unsigned mq [NQ][$];
    bit m_run;
    int m_ptr;
    int m_pend;
    int md_tgt;
    bit md_legal, md_acc, md_ret;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run  = 0;
            m_ptr  = 0;
            m_pend = 0;
            for (int q = 0; q < NQ; q++) mq[q].delete();
        end else begin
            md_legal = sub_gfx || (sub_qid != 0 && int'(sub_qid) < NQ);
            md_tgt   = sub_gfx ? 0 : int'(sub_qid);
            md_acc   = sub_valid && md_legal && (mq[md_tgt].size() < DEPTH);
            md_ret   = 0;
            if (!m_run) begin
                for (int i = 0; i < NQ; i++) begin
                    int j;
                    j = (m_ptr + i) % NQ;
                    if (mq[j].size() > 0) begin
                        m_ptr = j;
                        m_run = 1;
                        break;
                    end
                end
            end else if (run_done) begin
                void'(mq[m_ptr].pop_front());
                md_ret = 1;
                m_ptr  = (m_ptr + 1) % NQ;
                m_run  = 0;
            end else if (run_yield) begin
                m_ptr = (m_ptr + 1) % NQ;
                m_run = 0;
            end
            if (md_acc) mq[md_tgt].push_back(int'(sub_task));
            m_pend = m_pend + int'(md_acc) - int'(md_ret);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_legal, e_ready;
            int e_tgt;
            e_legal = sub_gfx || (sub_qid != 0 && int'(sub_qid) < NQ);
            e_tgt   = sub_gfx ? 0 : int'(sub_qid);
            e_ready = e_legal && (mq[e_tgt].size() < DEPTH);
            check(run_valid == m_run, "R6 run_valid", run_valid, m_run);
            if (m_run && run_valid) begin
                check(int'(run_qid) == m_ptr, "R5 run_qid", run_qid, m_ptr);
                check(int'(run_task) == int'(mq[m_ptr][0]), "R8 run_task", run_task, mq[m_ptr][0]);
            end
            check(int'(pending) == m_pend, "R10 pending", pending, m_pend);
            check(idle == (m_pend == 0), "R11 idle", idle, m_pend == 0);
            check(sub_ready == e_ready, "R4 sub_ready", sub_ready, e_ready);
            check(sub_bad == (sub_valid && !e_legal), "R3 sub_bad", sub_bad, sub_valid && !e_legal);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_grant(input int exp_q, input int exp_t, input string tag);
        int n;
        n = 0;
        while (!run_valid && n < 300) begin
            cyc();
            n++;
        end
        check(run_valid == 1'b1, tag, run_valid, 1);
        check(int'(run_qid) == exp_q, tag, run_qid, exp_q);
        check(int'(run_task) == exp_t, tag, run_task, exp_t);
    endtask

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int unsigned lf;
        lf = 32'h1234_5678;
        repeat (4) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        check(idle == 1'b1, "R1 idle", idle, 1);
        check(pending == '0, "R1 pending", pending, 0);
        check(run_valid == 1'b0, "R1 run_valid", run_valid, 0);
        repeat (5) cyc();
        // R12 no grant with all queues empty
        check(run_valid == 1'b0, "R12 empty no grant", run_valid, 0);

        // R2 graphics submission with junk index
        sub_valid = 1; sub_gfx = 1; sub_qid = 6'd33; sub_task = 16'h0A01;
        cyc();
        sub_valid = 0; sub_gfx = 0;
        check(int'(pending) == 1, "R10 pending after gfx", pending, 1);
        check(idle == 1'b0, "R11 not idle", idle, 0);

        // R4 fill compute queue 5
        for (int k = 0; k < DEPTH; k++) begin
            sub_valid = 1; sub_qid = 6'd5; sub_task = 16'h0500 + 16'(k);
            cyc();
        end
        sub_task = 16'h0599;
        #1;
        check(sub_ready == 1'b0, "R4 full queue not ready", sub_ready, 0);
        cyc();
        sub_valid = 0;
        check(int'(pending) == 5, "R4 full drop pending", pending, 5);

        // R3 illegal compute indices
        sub_valid = 1; sub_gfx = 0; sub_qid = 6'd0;
        #1;
        check(sub_bad == 1'b1, "R3 qid0 bad", sub_bad, 1);
        check(sub_ready == 1'b0, "R3 qid0 ready", sub_ready, 0);
        cyc();
        sub_qid = 6'd57;
        #1;
        check(sub_bad == 1'b1, "R3 qid57 bad", sub_bad, 1);
        cyc();
        sub_qid = 6'd63;
        cyc();
        sub_valid = 0;
        check(int'(pending) == 5, "R3 pending unchanged", pending, 5);

        // R5 first grant at queue 0
        wait_grant(0, 16'h0A01, "R2 gfx grant q0");
        // R8 yield keeps task, moves on
        run_yield = 1;
        cyc();
        run_yield = 0;
        wait_grant(5, 16'h0500, "R8 after yield q5");
        // R7 retire
        run_done = 1;
        cyc();
        run_done = 0;
        check(int'(pending) == 4, "R7 pending after done", pending, 4);
        wait_grant(0, 16'h0A01, "R8 yielded task still head");
        // R9 done and yield together retire
        run_done = 1; run_yield = 1;
        cyc();
        run_done = 0; run_yield = 0;
        check(int'(pending) == 3, "R9 retire wins", pending, 3);
        wait_grant(5, 16'h0501, "R9 next q5");
        // R10 simultaneous submit and retire
        run_done = 1; sub_valid = 1; sub_gfx = 0; sub_qid = 6'd9; sub_task = 16'h0900;
        cyc();
        run_done = 0; sub_valid = 0;
        check(int'(pending) == 3, "R10 inc and dec", pending, 3);
        wait_grant(9, 16'h0900, "R7 pointer past q5");

        // Random traffic
        for (int c = 0; c < 6000; c++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            sub_valid = lf[0] & lf[1];
            sub_gfx   = lf[2] & lf[3] & lf[4];
            sub_qid   = QW'(lf[13:8]);
            sub_task  = lf[31:16];
            run_done  = run_valid && lf[5];
            run_yield = run_valid && lf[6];
            cyc();
        end
        sub_valid = 0; run_yield = 0;
        // Drain
        for (int c = 0; c < 4000 && !idle; c++) begin
            run_done = run_valid;
            cyc();
        end
        run_done = 0;
        cyc();
        check(idle == 1'b1, "R11 drained idle", idle, 1);
        check(pending == '0, "R11 drained pending", pending, 0);
        repeat (3) cyc();
        check(run_valid == 1'b0, "R12 drained no grant", run_valid, 0);
        summary();
    end
endmodule